// File: doc/BRIEF.md
# I2C Controller Bus Fault Classifier

This block sits beside the bit-level state machine of an I2C controller. It watches the synchronized SCL and SDA samples and sorts bus disturbances into three fault types that can occur when several controllers share a bus. SDA interference is lost arbitration: the controller releases SDA high but sees it low while SCL is high. SDA instability is SDA moving while SCL stays high through a clock-high phase, which is an unexpected Start or Stop. SCL interference is another controller pulling SCL low early, which is clock synchronization.

A settle counter holds off SDA interference checks after each change of the driven SDA value. This lets the line reach its new level first. Both SDA fault types raise one arbitration-lost pulse. The block tracks whether a transaction it started is under way and asks the controller to return to idle when a fault ends that transaction. SCL interference can be masked, because on a bus with several controllers it is normal behaviour.

Top module: `i2c_flt_sorter`

## Requirements
- R1: When the driven SDA value differs from its value on the previous clock, an 11-bit settle counter loads rise time + RTT_CYC - 1 (RTT_CYC defaults to 4). It then counts down by one per clock and holds at zero.
- R2: `sda_interf_o` is 1 only when all of the following hold: `xmit_i` is 1, the settle counter is zero, `scl_i` is 1, and `sda_i` differs from the driven SDA value registered on the previous clock.
- R3: `sda_interf_o` is 0 whenever `scl_i` is 0.
- R4: `sda_unstable_o` is 1 only when all of the following hold: `hi_phase_i` is 1, `scl_i` is 1 both now and on the previous clock, and `sda_i` differs from its previous-clock sample.
- R5: `scl_interf_o` is 1 when `hi_phase_i` is 1, `scl_i` was 1 on the previous clock and is 0 now, and `scl_mask_i` is 0.
- R6: While `scl_mask_i` is 1, `scl_interf_o` stays 0.
- R7: `arb_lost_o` equals `sda_unstable_o` OR `sda_interf_o`.
- R8: `txn_started_o` is set one clock after `start_seen_i` is sampled with `host_en_i` high. A further Start while it is set changes nothing. It clears one clock after `stop_seen_i` is high, `host_en_i` is low, or `arb_lost_o` is high.
- R9: `abort_o` is 1 when `sda_interf_o` is 1 while `txn_started_o` is set, or when `sda_unstable_o` is 1. SDA interference alone, with no transaction started, does not raise it.
- R10: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronized SCL sample |
| sda_i | input | 1 | Synchronized SDA sample |
| sda_drv_i | input | 1 | SDA value the controller drives (1 = released) |
| xmit_i | input | 1 | Controller is transmitting |
| hi_phase_i | input | 1 | Controller is in a clock-high phase |
| host_en_i | input | 1 | Host mode enabled |
| start_seen_i | input | 1 | Start condition observed strobe |
| stop_seen_i | input | 1 | Stop condition observed strobe |
| rise_time_i | input | 10 | Programmed rise time in clocks |
| scl_mask_i | input | 1 | Suppresses SCL interference events |
| sda_interf_o | output | 1 | SDA interference pulse |
| sda_unstable_o | output | 1 | Unexpected Start/Stop pulse |
| scl_interf_o | output | 1 | SCL interference pulse |
| arb_lost_o | output | 1 | Arbitration lost pulse |
| txn_started_o | output | 1 | Transaction in progress |
| abort_o | output | 1 | Request that the controller return to idle |

## Verification
The hardest case to reach is the settle window. An SDA mismatch must stay silent while the counter runs and must be flagged on the exact clock it reaches zero. To test this, the bench holds SCL high and SDA low with transmit asserted, then flips the driven value. It checks the interference output after each clock, expecting 0 for rise time + RTT_CYC - 1 clocks and 1 on the next one. The abort path needs a transaction that was already started before the mismatch, so the bench logs a Start first.

// File: rtl/i2c_flt_pkg.sv
package i2c_flt_pkg;
  localparam int unsigned RISE_W  = 10;
  localparam int unsigned CNT_W   = 11;
  localparam int unsigned RTT_CYC = 4;

  typedef struct packed {
    logic scl;
    logic sda;
    logic drv;
  } line_smp_t;
endpackage

// File: rtl/i2c_flt_sampler.sv
module i2c_flt_sampler
  import i2c_flt_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  line_smp_t cur_i,
  output line_smp_t prev_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_o <= '0;
    else         prev_o <= cur_i;
  end
endmodule

// File: rtl/i2c_flt_settle.sv
module i2c_flt_settle #(
  parameter int unsigned RiseW = 10,
  parameter int unsigned CntW  = 11,
  parameter int unsigned Rtt   = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            drv_chg_i,
  input  logic [RiseW-1:0] rise_i,
  output logic            settled_o
);
  localparam logic [CntW-1:0] RttM1 = CntW'(Rtt - 1);

  logic [CntW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (drv_chg_i)       cnt_q <= CntW'(rise_i) + RttM1;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign settled_o = (cnt_q == '0);

  p_hold_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !drv_chg_i) |=> (cnt_q == '0));
  p_count_down_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !drv_chg_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/i2c_flt_txn.sv
module i2c_flt_txn (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic host_en_i,
  input  logic start_i,
  input  logic stop_i,
  input  logic arb_lost_i,
  output logic started_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      started_o <= 1'b0;
    else if (started_o && (!host_en_i || arb_lost_i || stop_i))
      started_o <= 1'b0;
    else if (start_i && host_en_i)
      started_o <= 1'b1;
  end

  p_clear_disable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_o && !host_en_i) |=> !started_o);
  p_clear_arb_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_o && arb_lost_i) |=> !started_o);
endmodule

// File: rtl/i2c_flt_sorter.sv
module i2c_flt_sorter
  import i2c_flt_pkg::*;
#(
  parameter int unsigned RiseW = RISE_W,
  parameter int unsigned CntW  = CNT_W,
  parameter int unsigned Rtt   = RTT_CYC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             sda_drv_i,
  input  logic             xmit_i,
  input  logic             hi_phase_i,
  input  logic             host_en_i,
  input  logic             start_seen_i,
  input  logic             stop_seen_i,
  input  logic [RiseW-1:0] rise_time_i,
  input  logic             scl_mask_i,
  output logic             sda_interf_o,
  output logic             sda_unstable_o,
  output logic             scl_interf_o,
  output logic             arb_lost_o,
  output logic             txn_started_o,
  output logic             abort_o
);
  line_smp_t cur, prev;
  logic      settled;

  assign cur = '{scl: scl_i, sda: sda_i, drv: sda_drv_i};

  i2c_flt_sampler u_smp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cur_i  (cur),
    .prev_o (prev)
  );

  i2c_flt_settle #(.RiseW(RiseW), .CntW(CntW), .Rtt(Rtt)) u_settle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .drv_chg_i (sda_drv_i != prev.drv),
    .rise_i    (rise_time_i),
    .settled_o (settled)
  );

  // compare against registered drive value: it moves with the counter reload
  assign sda_interf_o   = xmit_i && settled && scl_i && (sda_i != prev.drv);
  assign sda_unstable_o = hi_phase_i && prev.scl && scl_i && (prev.sda != sda_i);
  assign scl_interf_o   = hi_phase_i && prev.scl && !scl_i && !scl_mask_i;
  assign arb_lost_o     = sda_unstable_o || sda_interf_o;
  assign abort_o        = (txn_started_o && sda_interf_o) || sda_unstable_o;

  i2c_flt_txn u_txn (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .host_en_i  (host_en_i),
    .start_i    (start_seen_i),
    .stop_i     (stop_seen_i),
    .arb_lost_i (arb_lost_o),
    .started_o  (txn_started_o)
  );

  p_quiet_scl_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scl_i |-> !sda_interf_o);
  p_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_mask_i |-> !scl_interf_o);
  p_abort_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> arb_lost_o);
  p_interf_settled_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_drv_i != prev.drv) |=> !sda_interf_o);
endmodule

// File: tb/test_i2c_flt_sorter.sv
module test_i2c_flt_sorter;
  localparam int CLK_PER = 10;
  localparam int RTT     = 4;
  localparam int RISE    = 3;
  localparam int LOAD    = RISE + RTT - 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic scl, sda, drv, xmit, hi, hen, st, sp, msk;
  logic [9:0] rise;
  logic o_si, o_su, o_ci, o_al, o_ts, o_ab;
  int vec = 0, errs = 0;

  always #(CLK_PER/2) clk = ~clk;

  i2c_flt_sorter i_i2c_flt_sorter (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl), .sda_i(sda), .sda_drv_i(drv),
    .xmit_i(xmit), .hi_phase_i(hi), .host_en_i(hen), .start_seen_i(st),
    .stop_seen_i(sp), .rise_time_i(rise), .scl_mask_i(msk),
    .sda_interf_o(o_si), .sda_unstable_o(o_su), .scl_interf_o(o_ci),
    .arb_lost_o(o_al), .txn_started_o(o_ts), .abort_o(o_ab)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    vec++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic idle_lines();
    @(negedge clk);
    scl = 1'b1; sda = 1'b1; drv = 1'b1; xmit = 1'b0; hi = 1'b0;
    st = 1'b0; sp = 1'b0; msk = 1'b0;
    for (int k = 0; k < LOAD + 3; k++) tick();
  endtask

  task automatic t_reset();
    chk("R10 sda_interf", o_si, 1'b0);
    chk("R10 sda_unstable", o_su, 1'b0);
    chk("R10 scl_interf", o_ci, 1'b0);
    chk("R10 arb_lost", o_al, 1'b0);
    chk("R10 txn_started", o_ts, 1'b0);
    chk("R10 abort", o_ab, 1'b0);
  endtask

  task automatic t_settle();
    idle_lines();
    @(negedge clk);
    drv = 1'b0;
    for (int k = 0; k < LOAD + 3; k++) tick();
    @(negedge clk);
    drv = 1'b1; sda = 1'b0; xmit = 1'b1; #1;
    chk("R2 same-cycle old drive matches", o_si, 1'b0);
    for (int k = 1; k <= LOAD + 1; k++) begin
      tick();
      chk("R1 R2 settle window", o_si, (k == LOAD + 1));
    end
    chk("R7 arb_lost follows interference", o_al, 1'b1);
    chk("R9 no abort without transaction", o_ab, 1'b0);
    @(negedge clk); scl = 1'b0; #1;
    chk("R3 no interference with SCL low", o_si, 1'b0);
    @(negedge clk); scl = 1'b1; xmit = 1'b0; #1;
    chk("R2 no interference when not transmitting", o_si, 1'b0);
  endtask

  task automatic t_unstable();
    idle_lines();
    @(negedge clk); hi = 1'b1; #1;
    chk("R4 quiet while SDA steady", o_su, 1'b0);
    @(negedge clk); sda = 1'b0; #1;
    chk("R4 SDA falls with SCL high", o_su, 1'b1);
    chk("R7 arb_lost on instability", o_al, 1'b1);
    chk("R9 abort on instability", o_ab, 1'b1);
    tick();
    chk("R4 single-cycle pulse", o_su, 1'b0);
    @(negedge clk); scl = 1'b0; tick();
    @(negedge clk); scl = 1'b1; sda = 1'b1; #1;
    chk("R4 no event when SCL was low", o_su, 1'b0);
    tick();
    @(negedge clk); hi = 1'b0; sda = 1'b0; #1;
    chk("R4 no event outside clock-high phase", o_su, 1'b0);
  endtask

  task automatic t_scl();
    idle_lines();
    @(negedge clk); hi = 1'b1; scl = 1'b0; #1;
    chk("R5 SCL pulled low early", o_ci, 1'b1);
    tick();
    chk("R5 single-cycle pulse", o_ci, 1'b0);
    @(negedge clk); scl = 1'b1; tick();
    @(negedge clk); msk = 1'b1; scl = 1'b0; #1;
    chk("R6 masked SCL interference", o_ci, 1'b0);
    @(negedge clk); hi = 1'b0; msk = 1'b0; scl = 1'b1; tick();
    @(negedge clk); scl = 1'b0; #1;
    chk("R5 no event outside clock-high phase", o_ci, 1'b0);
  endtask

  task automatic t_txn();
    idle_lines();
    @(negedge clk); st = 1'b1; tick();
    st = 1'b0; #1;
    chk("R8 start sets flag", o_ts, 1'b1);
    @(negedge clk); st = 1'b1; tick(); st = 1'b0; #1;
    chk("R8 repeated start keeps flag", o_ts, 1'b1);
    @(negedge clk); sp = 1'b1; tick(); sp = 1'b0; #1;
    chk("R8 stop clears flag", o_ts, 1'b0);
    @(negedge clk); st = 1'b1; tick(); st = 1'b0; #1;
    @(negedge clk); hen = 1'b0; tick(); #1;
    chk("R8 disable clears flag", o_ts, 1'b0);
    @(negedge clk); hen = 1'b1; st = 1'b1; tick(); st = 1'b0; #1;
    chk("R8 flag set again", o_ts, 1'b1);
    @(negedge clk); sda = 1'b0; xmit = 1'b1; #1;
    chk("R2 interference in transaction", o_si, 1'b1);
    chk("R9 abort with transaction", o_ab, 1'b1);
    tick();
    chk("R8 arbitration loss clears flag", o_ts, 1'b0);
    chk("R9 abort drops with flag", o_ab, 1'b0);
    @(negedge clk); xmit = 1'b0; sda = 1'b1;
  endtask

  initial begin
    scl = 1'b1; sda = 1'b1; drv = 1'b0; xmit = 1'b0; hi = 1'b0;
    hen = 1'b1; st = 1'b0; sp = 1'b0; msk = 1'b0; rise = 10'(RISE);
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_ni = 1'b1;
    t_settle();
    t_unstable();
    t_scl();
    t_txn();
    $display("== %0d vectors applied, %0d miscompares ==", vec, errs);
    $finish;
  end

  initial begin
    #(CLK_PER * 20000);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, errs);
    $finish;
  end
endmodule